// File: doc/BRIEF.md
# Wide-Result Signed Adder-Subtractor

This block adds or subtracts two N-bit two's-complement operands in pure combinational logic. A single mode input picks the operation; subtraction is done by inverting the second operand bit by bit and injecting a one into the lowest carry, so one ripple chain of full-adder cells serves both operations. The block has no clock and no state: its outputs follow the inputs after the ripple delay.

The result comes out 2N bits wide on two buses. The low bus carries the N-bit wrapped sum. The high bus carries the upper half of the exact signed result. The sign is taken from the sum MSB, corrected by the overflow flag, and never from the carry. The unsigned carry leaving the top cell and the signed overflow flag are driven as two separate outputs, so a consumer can use either unsigned or signed semantics without extra logic.

Top module: `addsub_wide`

## Requirements
- R1: `res_lo` equals (A + B) mod 2^N when `sub_mode` is 0, and (A - B) mod 2^N when `sub_mode` is 1.
- R2: Subtraction is formed as A + (B XOR all-ones) + 1, the mode bit acting both as the inversion mask and as the carry into bit 0; with `sub_mode` 0, B passes through unchanged and the carry into bit 0 is 0.
- R3: `carry_out` is the carry leaving the top cell: on add it is 1 exactly when unsigned A + B is at least 2^N; on subtract it is 1 exactly when unsigned A is greater than or equal to unsigned B (no borrow).
- R4: On add, `ovf` is 1 exactly when A and B have the same sign bit and the sign bit of `res_lo` differs from it.
- R5: On subtract, `ovf` is 1 exactly when A and B have different sign bits and the sign bit of `res_lo` differs from that of A (for N=4, 5 - (-3) gives `res_lo` 1000 with `ovf` 1).
- R6: When `ovf` is 0, every bit of `res_hi` equals bit N-1 of `res_lo`; the carry never sets the sign (for N=3, 3 - 2 gives `res_lo` 001, `res_hi` 000, `carry_out` 1).
- R7: When `ovf` is 1, every bit of `res_hi` equals the inverse of bit N-1 of `res_lo`, so {`res_hi`, `res_lo`} is always the exact 2N-bit signed result (for N=3, (-3) + (-3) gives {111, 010}).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | N | First operand, two's complement |
| op_b | input | N | Second operand, two's complement |
| sub_mode | input | 1 | 0 selects A + B, 1 selects A - B |
| res_lo | output | N | Lower half of the result (wrapped N-bit sum) |
| res_hi | output | N | Upper half of the exact signed result |
| carry_out | output | 1 | Carry leaving the top full-adder cell |
| ovf | output | 1 | Signed overflow of the N-bit result |

## Verification
The bench sweeps every operand pair in both modes at N=4 and compares the 2N-bit result, carry and overflow against wide integer arithmetic, which catches a design that sign-extends from the carry (3 - 2 would read as negative) or that applies the add overflow rule to subtraction (5 - (-3) would show no overflow). Directed cases at N=3 and N=6 check the cancelling sum 1 + (-1), where a design that confuses carry with overflow would raise `ovf`, and the doubled negative (-3) + (-3), where a plain sign copy would give a positive upper half. A missing carry injection shows up as every subtraction being short by one, and an unconnected top carry as `carry_out` stuck.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_e;
endpackage

// File: rtl/addsub_fa_cell.sv
module addsub_fa_cell (
    input  logic x_i,
    input  logic y_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);
    always_comb begin
        s_o = x_i ^ y_i ^ c_i;
        c_o = (x_i & y_i) | (x_i & c_i) | (y_i & c_i);
    end
endmodule

// File: rtl/addsub_ripple.sv
module addsub_ripple #(
    parameter int N = 8
) (
    input  logic [N-1:0]    a_i,
    input  logic [N-1:0]    b_i,
    input  addsub_pkg::op_e mode_i,
    output logic [N-1:0]    sum_o,
    output logic            b_eff_msb_o,
    output logic            carry_top_o
);
    logic [N-1:0] b_eff_d;
    logic [N:0]   chain_d;

    always_comb begin
        b_eff_d    = b_i ^ {N{mode_i == addsub_pkg::OP_SUB}};
        chain_d[0] = (mode_i == addsub_pkg::OP_SUB);
    end

    for (genvar g = 0; g < N; g++) begin : g_cell
        addsub_fa_cell cell_i (
            .x_i (a_i[g]),
            .y_i (b_eff_d[g]),
            .c_i (chain_d[g]),
            .s_o (sum_o[g]),
            .c_o (chain_d[g+1])
        );
    end

    assign b_eff_msb_o = b_eff_d[N-1];
    assign carry_top_o = chain_d[N];
endmodule

// File: rtl/addsub_ext_flags.sv
module addsub_ext_flags #(
    parameter int N = 8
) (
    input  logic         a_msb_i,
    input  logic         b_eff_msb_i,
    input  logic         sum_msb_i,
    input  logic         carry_top_i,
    output logic [N-1:0] hi_o,
    output logic         ovf_o,
    output logic         carry_o
);
    typedef struct packed {
        logic [N-1:0] hi;
        logic         ovf;
        logic         carry;
    } ext_t;

    ext_t ext_d;

    always_comb begin
        ext_d       = '0;
        ext_d.ovf   = (a_msb_i == b_eff_msb_i) && (sum_msb_i != a_msb_i);
        ext_d.hi    = {N{sum_msb_i ^ ext_d.ovf}};
        ext_d.carry = carry_top_i;
    end

    assign hi_o    = ext_d.hi;
    assign ovf_o   = ext_d.ovf;
    assign carry_o = ext_d.carry;
endmodule

// File: rtl/addsub_wide.sv
module addsub_wide #(
    parameter int N = 8
) (
    input  logic [N-1:0] op_a,
    input  logic [N-1:0] op_b,
    input  logic         sub_mode,
    output logic [N-1:0] res_lo,
    output logic [N-1:0] res_hi,
    output logic         carry_out,
    output logic         ovf
);
    addsub_pkg::op_e mode_d;
    logic [N-1:0]    sum_d;
    logic            b_eff_msb_d;
    logic            carry_top_d;

    assign mode_d = addsub_pkg::op_e'(sub_mode);

    addsub_ripple #(.N(N)) ripple_i (
        .a_i         (op_a),
        .b_i         (op_b),
        .mode_i      (mode_d),
        .sum_o       (sum_d),
        .b_eff_msb_o (b_eff_msb_d),
        .carry_top_o (carry_top_d)
    );

    addsub_ext_flags #(.N(N)) flags_i (
        .a_msb_i     (op_a[N-1]),
        .b_eff_msb_i (b_eff_msb_d),
        .sum_msb_i   (sum_d[N-1]),
        .carry_top_i (carry_top_d),
        .hi_o        (res_hi),
        .ovf_o       (ovf),
        .carry_o     (carry_out)
    );

    assign res_lo = sum_d;
endmodule

// File: rtl/addsub_wide_chk.sv
module addsub_wide_chk #(
    parameter int N = 8
) (
    input logic [N-1:0] op_a,
    input logic [N-1:0] op_b,
    input logic         sub_mode,
    input logic [N-1:0] res_lo,
    input logic [N-1:0] res_hi,
    input logic         carry_out,
    input logic         ovf
);
    logic [N:0] wide_sum;
    logic       known;

    always_comb begin
        known    = !$isunknown({op_a, op_b, sub_mode, res_lo, res_hi, carry_out, ovf});
        wide_sum = sub_mode ? ({1'b0, op_a} - {1'b0, op_b}) : ({1'b0, op_a} + {1'b0, op_b});
        if (known) begin
            assert_lo_value_R1: assert (res_lo == wide_sum[N-1:0]);
            assert_carry_R3: assert (carry_out == (sub_mode ? (op_a >= op_b) : wide_sum[N]));
            assert_add_ovf_signs_R4: assert (!(ovf && !sub_mode) || (op_a[N-1] == op_b[N-1]));
            assert_sub_ovf_signs_R5: assert (!(ovf && sub_mode) || (op_a[N-1] != op_b[N-1]));
            assert_hi_copy_R6: assert (ovf || (res_hi == {N{res_lo[N-1]}}));
            assert_hi_invert_R7: assert (!ovf || (res_hi == {N{~res_lo[N-1]}}));
        end
    end
endmodule

bind addsub_wide addsub_wide_chk #(.N(N)) chk_i (
    .op_a      (op_a),
    .op_b      (op_b),
    .sub_mode  (sub_mode),
    .res_lo    (res_lo),
    .res_hi    (res_hi),
    .carry_out (carry_out),
    .ovf       (ovf)
);

// File: tb/addsub_wide_tb_top.sv
module addsub_wide_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    logic [3:0] a4, b4, lo4, hi4;
    logic       m4, c4, v4;
    logic [2:0] a3, b3, lo3, hi3;
    logic       m3, c3, v3;
    logic [5:0] a6, b6, lo6, hi6;
    logic       m6, c6, v6;

    addsub_wide #(.N(4)) dut_i (
        .op_a(a4), .op_b(b4), .sub_mode(m4),
        .res_lo(lo4), .res_hi(hi4), .carry_out(c4), .ovf(v4)
    );
    addsub_wide #(.N(3)) dut3_i (
        .op_a(a3), .op_b(b3), .sub_mode(m3),
        .res_lo(lo3), .res_hi(hi3), .carry_out(c3), .ovf(v3)
    );
    addsub_wide #(.N(6)) dut6_i (
        .op_a(a6), .op_b(b6), .sub_mode(m6),
        .res_lo(lo6), .res_hi(hi6), .carry_out(c6), .ovf(v6)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic t_reset_zero();
        a4 = '0; b4 = '0; m4 = 1'b0;
        @(negedge clk);
        chk("R1 zero inputs lo", 32'(lo4), 32'h0);
        chk("R6 zero inputs hi", 32'(hi4), 32'h0);
        chk("R3 zero inputs carry", 32'(c4), 32'h0);
        chk("R4 zero inputs ovf", 32'(v4), 32'h0);
    endtask

    task automatic t_sweep4();
        for (int m = 0; m < 2; m++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    int sa, sb, full, ucarry;
                    logic exp_v;
                    logic [7:0] exp_w;
                    a4 = 4'(a); b4 = 4'(b); m4 = m[0];
                    @(negedge clk);
                    sa = (a > 7) ? a - 16 : a;
                    sb = (b > 7) ? b - 16 : b;
                    full = m[0] ? sa - sb : sa + sb;
                    exp_w = 8'(full);
                    exp_v = (full > 7) || (full < -8);
                    ucarry = m[0] ? int'(a >= b) : int'(a + b >= 16);
                    if (m[0]) begin
                        chk("R1 R2 sweep sub lo", 32'(lo4), 32'(exp_w[3:0]));
                        chk("R5 sweep sub ovf", 32'(v4), 32'(exp_v));
                    end else begin
                        chk("R1 sweep add lo", 32'(lo4), 32'(exp_w[3:0]));
                        chk("R4 sweep add ovf", 32'(v4), 32'(exp_v));
                    end
                    chk("R3 sweep carry", 32'(c4), 32'(ucarry));
                    if (exp_v) chk("R7 sweep wide result", 32'({hi4, lo4}), 32'(exp_w));
                    else       chk("R6 sweep wide result", 32'({hi4, lo4}), 32'(exp_w));
                end
            end
        end
    endtask

    task automatic t_sub_carry_not_sign3();
        a3 = 3'b011; b3 = 3'b010; m3 = 1'b1;
        @(negedge clk);
        chk("R2 3-2 lo", 32'(lo3), 32'b001);
        chk("R6 3-2 hi", 32'(hi3), 32'b000);
        chk("R3 3-2 carry", 32'(c3), 32'h1);
        chk("R5 3-2 ovf", 32'(v3), 32'h0);
    endtask

    task automatic t_double_neg3();
        a3 = 3'b101; b3 = 3'b101; m3 = 1'b0;
        @(negedge clk);
        chk("R1 -3+-3 lo", 32'(lo3), 32'b010);
        chk("R4 -3+-3 ovf", 32'(v3), 32'h1);
        chk("R7 -3+-3 hi", 32'(hi3), 32'b111);
        chk("R3 -3+-3 carry", 32'(c3), 32'h1);
    endtask

    task automatic t_cancel6();
        a6 = 6'b000001; b6 = 6'b111111; m6 = 1'b0;
        @(negedge clk);
        chk("R1 1+-1 lo", 32'(lo6), 32'h0);
        chk("R4 1+-1 ovf", 32'(v6), 32'h0);
        chk("R3 1+-1 carry", 32'(c6), 32'h1);
        chk("R6 1+-1 hi", 32'(hi6), 32'h0);
    endtask

    task automatic t_sub_ovf4();
        a4 = 4'b0101; b4 = 4'b1101; m4 = 1'b1;
        @(negedge clk);
        chk("R5 5-(-3) ovf", 32'(v4), 32'h1);
        chk("R1 5-(-3) lo", 32'(lo4), 32'b1000);
        chk("R7 5-(-3) hi", 32'(hi4), 32'b0000);
        chk("R3 5-(-3) carry", 32'(c4), 32'h0);
    endtask

    initial begin
        a3 = '0; b3 = '0; m3 = 1'b0;
        a6 = '0; b6 = '0; m6 = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        t_reset_zero();
        t_sweep4();
        t_sub_carry_not_sign3();
        t_double_neg3();
        t_cancel6();
        t_sub_ovf4();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !done) begin
            failures = failures + 1;
            $display("FAIL watchdog actual=%0d expected=below 20000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule